// File: doc/BRIEF.md
# Device Power State Transition Controller

This block keeps the device power state of a PCI-style function and applies software writes to its 2-bit power state field. Every write is judged against the current state. A move to any deeper (lower-power) state is accepted. A move toward more power is accepted only when it targets full power (D0). Any other request is dropped, and the state stays where it was.

A return to D0 triggers a side effect that depends on the state being left. Waking from D1 or D2 sets a wake status bit. While the mask input is low, that bit drives an active-low interrupt to the secondary side, and software clears it by writing a one. Waking from D3hot instead starts a chip reset. The secondary reset output is held low for a parameterised number of cycles (100 ms at the system clock by default). A one-cycle preload start pulse follows, and the block then stays busy until the external preload engine reports done. Moves into deeper states have no side effect. D3cold is left only through the ordinary power-on reset.

Top module: `pm_state_ctrl`

## Requirements
- R1: After reset the state is D0 (00), the wake status is 0, sec_irq_n and sec_rst_n are 1, and preload_start and busy are 0.
- R2: The state encoding is D0=00, D1=01, D2=10, D3hot=11. A write with a code larger than the current state is accepted and shows on pwr_state in the cycle after the write.
- R3: A write with a nonzero code smaller than the current state is ignored. A write of the current state changes nothing.
- R4: An accepted write of 00 while in D1 or D2 sets d0_status in the cycle after the write.
- R5: sec_irq_n is low exactly when d0_status is 1 and evt_mask is 0. It follows evt_mask without a clock delay.
- R6: A write with cfg_wr_clr=1 clears d0_status in the next cycle. If the same write also sets the bit (R4), the set wins.
- R7: An accepted write of 00 while in D3hot puts the state at D0 and clears d0_status in the next cycle. sec_rst_n is then low for exactly RST_CYCLES cycles, starting in that same next cycle.
- R8: preload_start pulses for one cycle in the first cycle after sec_rst_n returns high. busy is high from the first reset cycle until the cycle after preload_done is seen, and preload_done counts only after the pulse.
- R9: While busy is high, every write is ignored, including state changes and status clears.
- R10: Moves into D1, D2 or D3hot leave sec_irq_n, sec_rst_n, preload_start and busy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_wr | input | 1 | Control/status register write strobe |
| cfg_wr_state | input | 2 | Requested power state code |
| cfg_wr_clr | input | 1 | Write-one-to-clear for the wake status bit |
| evt_mask | input | 1 | Masks the wake interrupt when high |
| preload_done | input | 1 | Preload engine finished |
| pwr_state | output | 2 | Current power state |
| d0_status | output | 1 | Wake-from-D1/D2 status bit |
| sec_irq_n | output | 1 | Active-low secondary interrupt |
| sec_rst_n | output | 1 | Active-low secondary reset |
| preload_start | output | 1 | One-cycle preload start pulse |
| busy | output | 1 | Reset/preload sequence in progress |

## Verification
pwr_state, d0_status, sec_rst_n, preload_start and busy all come from registers, so each result is due one clock after the edge that samples the write or done input. sec_irq_n also follows evt_mask within the same cycle. The bench drives its inputs on the falling edge and updates its reference model on the rising edge that samples them. It compares every output at the next falling edge, so the model and the design are always matched against the same edge. The reset length is shortened to 8 cycles, which lets the whole D3hot sequence be checked cycle by cycle.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PS_D0    = 2'b00,
        PS_D1    = 2'b01,
        PS_D2    = 2'b10,
        PS_D3HOT = 2'b11
    } pm_state_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RESET = 2'd1,
        SEQ_START = 2'd2,
        SEQ_WAIT  = 2'd3
    } seq_phase_e;

    typedef struct packed {
        pm_state_e state;
    } top_regs_t;

endpackage

// File: rtl/pm_trans_check.sv
module pm_trans_check
    import pm_pkg::*;
(
    input  logic      wr,
    input  logic      blocked,
    input  pm_state_e cur,
    input  pm_state_e req,
    output logic      accept,
    output logic      wake_soft,
    output logic      wake_hot
);

    logic deeper;
    logic to_full;

    always_comb begin
        deeper    = req > cur;
        to_full   = (req == PS_D0) && (cur != PS_D0);
        accept    = wr && !blocked && (deeper || to_full);
        wake_soft = accept && to_full && ((cur == PS_D1) || (cur == PS_D2));
        wake_hot  = accept && to_full && (cur == PS_D3HOT);
    end

endmodule

// File: rtl/pm_d0_event.sv
module pm_d0_event (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic chip_rst,
    input  logic mask,
    output logic status,
    output logic irq_n
);

    typedef struct packed {
        logic status;
    } evt_regs_t;

    evt_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (chip_rst) begin
            r_d.status = 1'b0;
        end else if (set_evt) begin
            r_d.status = 1'b1;
        end else if (clr_evt) begin
            r_d.status = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign status = r_q.status;
    assign irq_n  = !(r_q.status && !mask);

    // R6: clear without a simultaneous set empties the bit
    a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !status);

    // R4: a set event is visible one cycle later
    a_r4_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && !chip_rst) |=> status);

endmodule

// File: rtl/pm_reset_seq.sv
module pm_reset_seq
    import pm_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 3_300_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic done,
    output logic sec_rst_n,
    output logic start,
    output logic busy
);

    localparam int unsigned CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    typedef struct packed {
        seq_phase_e    phase;
        logic [CW-1:0] cnt;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.phase)
            SEQ_IDLE: begin
                if (kick) begin
                    r_d.phase = SEQ_RESET;
                    r_d.cnt   = '0;
                end
            end
            SEQ_RESET: begin
                if (r_q.cnt == LAST) begin
                    r_d.phase = SEQ_START;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            SEQ_START: r_d.phase = SEQ_WAIT;
            SEQ_WAIT:  if (done) r_d.phase = SEQ_IDLE;
            default:   r_d.phase = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{phase: SEQ_IDLE, cnt: '0};
        else        r_q <= r_d;
    end

    assign sec_rst_n = (r_q.phase != SEQ_RESET);
    assign start     = (r_q.phase == SEQ_START);
    assign busy      = (r_q.phase != SEQ_IDLE);

    // R7: the reset counter never passes the programmed length
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < CW'(RST_CYCLES));

    // R8: the start pulse lasts one cycle
    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R8: the start pulse follows the end of the reset
    a_r8_start_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_rst_n) |-> start);

endmodule

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
    import pm_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 3_300_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_wr_state,
    input  logic       cfg_wr_clr,
    input  logic       evt_mask,
    input  logic       preload_done,
    output logic [1:0] pwr_state,
    output logic       d0_status,
    output logic       sec_irq_n,
    output logic       sec_rst_n,
    output logic       preload_start,
    output logic       busy
);

    top_regs_t r_q, r_d;
    logic      accept;
    logic      wake_soft;
    logic      wake_hot;
    logic      clr_ok;

    pm_trans_check u_chk (
        .wr        (cfg_wr),
        .blocked   (busy),
        .cur       (r_q.state),
        .req       (pm_state_e'(cfg_wr_state)),
        .accept    (accept),
        .wake_soft (wake_soft),
        .wake_hot  (wake_hot)
    );

    assign clr_ok = cfg_wr && cfg_wr_clr && !busy;

    pm_d0_event u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (wake_soft),
        .clr_evt  (clr_ok),
        .chip_rst (wake_hot),
        .mask     (evt_mask),
        .status   (d0_status),
        .irq_n    (sec_irq_n)
    );

    pm_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick      (wake_hot),
        .done      (preload_done),
        .sec_rst_n (sec_rst_n),
        .start     (preload_start),
        .busy      (busy)
    );

    always_comb begin
        r_d = r_q;
        if (accept) r_d.state = pm_state_e'(cfg_wr_state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: PS_D0};
        else        r_q <= r_d;
    end

    assign pwr_state = r_q.state;

    // R3: a non-D0 request for more power leaves the state alone
    a_r3_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_wr_state != 2'b00) && (cfg_wr_state < pwr_state))
        |=> $stable(pwr_state));

    // R9: writes while busy change nothing
    a_r9_busy_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr) |=> ($stable(pwr_state) && $stable(d0_status)));

    // R7: leaving D3hot for D0 pulls the secondary reset low
    a_r7_hot_wake_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !busy && (pwr_state == 2'b11) && (cfg_wr_state == 2'b00))
        |=> (!sec_rst_n && (pwr_state == 2'b00) && !d0_status));

    // R5: interrupt is never active while masked
    a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        evt_mask |-> sec_irq_n);

    // R10: deeper moves trigger no reset sequence
    a_r10_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_wr && (cfg_wr_state > pwr_state)) |=> !busy);

endmodule

// File: tb/sim_pm_state_ctrl.sv
module sim_pm_state_ctrl;

    localparam int unsigned RST_CYC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_wr_state = 2'b00;
    logic       cfg_wr_clr = 1'b0;
    logic       evt_mask = 1'b0;
    logic       preload_done = 1'b0;
    logic [1:0] pwr_state;
    logic       d0_status;
    logic       sec_irq_n;
    logic       sec_rst_n;
    logic       preload_start;
    logic       busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference model
    int m_st = 0;
    int m_status = 0;
    int m_phase = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    pm_state_ctrl #(.RST_CYCLES(RST_CYC)) u0 (
        .clk, .rst_n, .cfg_wr, .cfg_wr_state, .cfg_wr_clr, .evt_mask,
        .preload_done, .pwr_state, .d0_status, .sec_irq_n, .sec_rst_n,
        .preload_start, .busy
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic int exp_irq_n(input int st, input logic msk);
        return (st == 1 && msk == 1'b0) ? 0 : 1;
    endfunction

    task automatic model_edge();
        int busy_m;
        int acc;
        int req;
        busy_m = (m_phase != 0);
        req = int'(cfg_wr_state);
        acc = cfg_wr && !busy_m && ((req > m_st) || (req == 0 && m_st != 0));
        if (acc && req == 0 && m_st == 3) m_status = 0;
        else if (acc && req == 0 && (m_st == 1 || m_st == 2)) m_status = 1;
        else if (cfg_wr && cfg_wr_clr && !busy_m) m_status = 0;
        case (m_phase)
            0: if (acc && req == 0 && m_st == 3) begin m_phase = 1; m_cnt = 0; end
            1: if (m_cnt == RST_CYC - 1) m_phase = 2; else m_cnt++;
            2: m_phase = 3;
            default: if (preload_done) m_phase = 0;
        endcase
        if (acc) m_st = req;
    endtask

    task automatic compare_all();
        chk("R2 R3 R9 pwr_state", int'(pwr_state), m_st);
        chk("R4 R6 R7 d0_status", int'(d0_status), m_status);
        chk("R5 sec_irq_n", int'(sec_irq_n), exp_irq_n(m_status, evt_mask));
        chk("R7 sec_rst_n", int'(sec_rst_n), (m_phase == 1) ? 0 : 1);
        chk("R8 preload_start", int'(preload_start), (m_phase == 2) ? 1 : 0);
        chk("R8 busy", int'(busy), (m_phase != 0) ? 1 : 0);
    endtask

    // called at a negedge with inputs set; returns at the following negedge
    task automatic step();
        @(posedge clk);
        model_edge();
        cyc++;
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [1:0] s, input logic c);
        cfg_wr = 1'b1; cfg_wr_state = s; cfg_wr_clr = c;
        step();
        cfg_wr = 1'b0; cfg_wr_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset values
        compare_all();
        rst_n = 1'b1;
        idle(2);

        // R2 / R10: deeper moves, no side effect
        wr(2'b10, 1'b0);
        chk("R10 busy after deeper move", int'(busy), 0);
        wr(2'b01, 1'b0);          // R3: illegal, ignored
        chk("R3 illegal request ignored", int'(pwr_state), 2);
        wr(2'b10, 1'b0);          // R3: same state
        // R4 / R5: wake masked, then unmasked
        evt_mask = 1'b1;
        wr(2'b00, 1'b0);
        chk("R5 masked irq high", int'(sec_irq_n), 1);
        evt_mask = 1'b0;
        #1 chk("R5 unmask drives irq low", int'(sec_irq_n), 0);
        // R6: clear
        wr(2'b00, 1'b1);
        chk("R6 status cleared", int'(d0_status), 0);
        // R6: set wins over clear
        wr(2'b01, 1'b0);
        wr(2'b00, 1'b1);
        chk("R6 set wins", int'(d0_status), 1);
        wr(2'b00, 1'b1);
        // R7 / R8 / R9: D3hot wake
        wr(2'b11, 1'b0);
        chk("R10 rst stays high on D3hot entry", int'(sec_rst_n), 1);
        wr(2'b00, 1'b0);
        chk("R7 state D0 after hot wake", int'(pwr_state), 0);
        wr(2'b10, 1'b0);          // R9: ignored while busy
        idle(RST_CYC + 3);
        preload_done = 1'b1;
        step();
        preload_done = 1'b0;
        chk("R8 busy clears after done", int'(busy), 0);
        wr(2'b01, 1'b0);
        chk("R9 writes accepted again", int'(pwr_state), 1);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            cfg_wr       = ($urandom_range(0, 99) < 40);
            cfg_wr_state = 2'($urandom_range(0, 3));
            cfg_wr_clr   = ($urandom_range(0, 99) < 25);
            evt_mask     = ($urandom_range(0, 99) < 20);
            preload_done = ($urandom_range(0, 99) < 30);
            step();
        end
        cfg_wr = 1'b0;
        finish_run();
    end

endmodule